// File: doc/BRIEF.md
# Sequential shift-add multiplier

This block multiplies two WIDTH-bit operands over several clock cycles with a single WIDTH-bit adder. A start pulse captures the operands. Each following cycle adds the multiplicand to an accumulator or skips the add, depending on the lowest bit of the multiplier register. The carry flop, the accumulator and the multiplier register then shift right together as one chain. After WIDTH such steps the double-width product sits in the accumulator (upper half) and the multiplier register (lower half).

A mode input, sampled together with start, selects unsigned or two's-complement operation. In two's-complement mode a negative multiplier causes both operands to be negated before the first step, so the multiplier bits walked by the sequencer are never negative. The partial product is then kept sign-extended on every shift. The multiplicand register is one bit wider than an operand, so negating the most negative value does not overflow.

The interface is a start pulse, a busy level and a one-cycle done pulse. The product stays on its output until the next accepted start.

Top module: `seq_mult`

## Requirements
- R1: After reset, busy and done are 0 and product is all zeros.
- R2: When busy is 0, a start pulse captures the operands and the mode, and busy is 1 from the next cycle for exactly WIDTH cycles.
- R3: done is high for exactly one cycle. It rises WIDTH clock edges after the edge that captured start, and it is never high while busy is high.
- R4: With signed_mode = 0, product equals multiplicand × multiplier taken as unsigned numbers, 2·WIDTH bits wide (for example 13 × 11 = 143 and 255 × 255 = 65025 at WIDTH 8).
- R5: With signed_mode = 1, both operands are two's complement and product is their two's-complement product in 2·WIDTH bits. This includes the most negative operand on either side (−128 × −128 = 16384 and −128 × 127 = −16256 at WIDTH 8).
- R6: A start pulse while busy is 1 is ignored. The running multiplication finishes on time with the result of the operands captured first.
- R7: While busy is 0 and no start is given, product keeps its value regardless of the operand and mode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Start pulse; captures the operands when the block is idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| multiplicand | input | WIDTH | Multiplicand operand |
| multiplier | input | WIDTH | Multiplier operand |
| busy | output | 1 | High while the add/shift steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2·WIDTH | Product, upper half from the accumulator and lower half from the multiplier register |

## Verification
The bench builds two copies of the block: one with WIDTH 8 and one with WIDTH 4. The 4-bit copy makes the whole operand space reachable, so every pair is run in both modes, including −8 × −8 and all sign combinations. The 8-bit copy runs a table of corners (all-ones operands, zero, the most negative value on either side) and random operands in both modes. It also covers the latency count, the single-cycle done pulse, a start given mid-run, and holding the product while idle.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;
  typedef enum logic [0:0] {
    SM_IDLE = 1'b0,
    SM_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/seq_mult_rst_sync.sv
module seq_mult_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/seq_mult_prep.sv
module seq_mult_prep #(
  parameter int WIDTH = 8
) (
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic [WIDTH:0]   mcand_ext,
  output logic [WIDTH-1:0] mplier_pos
);
  logic           flip;
  logic [WIDTH:0] mcand_wide;

  always_comb begin
    flip       = signed_mode & multiplier[WIDTH-1];
    mcand_wide = {signed_mode & multiplicand[WIDTH-1], multiplicand};
    mcand_ext  = flip ? (~mcand_wide + 1'b1) : mcand_wide;
    mplier_pos = flip ? (~multiplier + 1'b1) : multiplier;
  end
endmodule

// File: rtl/seq_mult_ctrl.sv
module seq_mult_ctrl
  import seq_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q, done_d;
  logic          last;

  assign last = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done_d  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    case (state_q)
      SM_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = SM_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SM_RUN: begin
        step   = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
        if (last) begin
          state_d = SM_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= SM_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q == SM_RUN);
  assign done = done_q;

  // R2
  start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (start && !busy) |=> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  // R3
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> (!busy && $past(busy)));

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (start && busy) |=> (done || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/seq_mult_dp.sv
module seq_mult_dp #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               load,
  input  logic               step,
  input  logic               signed_mode,
  input  logic [WIDTH:0]     mcand_ext,
  input  logic [WIDTH-1:0]   mplier_pos,
  output logic [2*WIDTH-1:0] product
);
  logic             c_q, c_d;
  logic [WIDTH-1:0] a_q, a_d;
  logic [WIDTH-1:0] q_q, q_d;
  logic [WIDTH:0]   m_q, m_d;
  logic             sgn_q, sgn_d;
  logic             reg_en;
  logic [WIDTH:0]   addend;
  logic [WIDTH:0]   sum;

  always_comb begin
    addend = q_q[0] ? m_q : '0;
    sum    = {c_q, a_q} + addend;
    c_d    = c_q;
    a_d    = a_q;
    q_d    = q_q;
    m_d    = m_q;
    sgn_d  = sgn_q;
    reg_en = load | step;
    if (load) begin
      c_d   = 1'b0;
      a_d   = '0;
      q_d   = mplier_pos;
      m_d   = mcand_ext;
      sgn_d = signed_mode;
    end else if (step) begin
      c_d = sgn_q & sum[WIDTH];
      a_d = sum[WIDTH:1];
      q_d = {sum[0], q_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      c_q   <= 1'b0;
      a_q   <= '0;
      q_q   <= '0;
      m_q   <= '0;
      sgn_q <= 1'b0;
    end else if (reg_en) begin
      c_q   <= c_d;
      a_q   <= a_d;
      q_q   <= q_d;
      m_q   <= m_d;
      sgn_q <= sgn_d;
    end
  end

  assign product = {a_q, q_q};
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               signed_mode,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic             rst_sn;
  logic             load, step;
  logic [WIDTH:0]   mcand_ext;
  logic [WIDTH-1:0] mplier_pos;

  seq_mult_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  seq_mult_prep #(.WIDTH(WIDTH)) u_prep (
    .signed_mode  (signed_mode),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .mcand_ext    (mcand_ext),
    .mplier_pos   (mplier_pos)
  );

  seq_mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rst_sn (rst_sn),
    .start  (start),
    .load   (load),
    .step   (step),
    .busy   (busy),
    .done   (done)
  );

  seq_mult_dp #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst_sn      (rst_sn),
    .load        (load),
    .step        (step),
    .signed_mode (signed_mode),
    .mcand_ext   (mcand_ext),
    .mplier_pos  (mplier_pos),
    .product     (product)
  );

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy && !start) |=> $stable(product));
endmodule

// File: tb/seq_mult_test.sv
module seq_mult_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {signed_mode, multiplicand, multiplier, expected product}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 8'd13,  8'd11,  16'h008F},
    {1'b0, 8'hFF,  8'hFF,  16'hFE01},
    {1'b0, 8'h00,  8'd200, 16'h0000},
    {1'b0, 8'd200, 8'h01,  16'h00C8},
    {1'b0, 8'h80,  8'h80,  16'h4000},
    {1'b1, 8'hF3,  8'd11,  16'hFF71},
    {1'b1, 8'd11,  8'hF3,  16'hFF71},
    {1'b1, 8'h80,  8'h80,  16'h4000},
    {1'b1, 8'h80,  8'h7F,  16'hC080},
    {1'b1, 8'h7F,  8'h80,  16'hC080},
    {1'b1, 8'hFF,  8'hFF,  16'h0001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start8 = 1'b0, smode8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic busy8, done8;
  logic [15:0] prod8;
  logic start4 = 1'b0, smode4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic busy4, done4;
  logic [7:0] prod4;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_mult #(.WIDTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start8), .signed_mode(smode8),
    .multiplicand(a8), .multiplier(b8), .busy(busy8), .done(done8), .product(prod8));

  seq_mult #(.WIDTH(4)) uut_n4 (
    .clk(clk), .rst_n(rst_n), .start(start4), .signed_mode(smode4),
    .multiplicand(a4), .multiplier(b4), .busy(busy4), .done(done4), .product(prod4));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp8(input logic m, input logic [7:0] a, input logic [7:0] b);
    if (m) return 16'($signed({{8{a[7]}}, a}) * $signed({{8{b[7]}}, b}));
    return {8'h00, a} * {8'h00, b};
  endfunction

  function automatic logic [7:0] exp4(input logic m, input logic [3:0] a, input logic [3:0] b);
    if (m) return 8'($signed({{4{a[3]}}, a}) * $signed({{4{b[3]}}, b}));
    return {4'h0, a} * {4'h0, b};
  endfunction

  task automatic run8(input logic m, input logic [7:0] a, input logic [7:0] b,
                      output logic [15:0] p, output int lat, output logic bsy1, output logic dn_after);
    @(negedge clk);
    smode8 = m; a8 = a; b8 = b; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    bsy1 = busy8;
    lat = 0;
    while (!done8 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    p = prod8;
    @(negedge clk);
    dn_after = done8;
  endtask

  task automatic run4(input logic m, input logic [3:0] a, input logic [3:0] b, output logic [7:0] p, output int lat);
    @(negedge clk);
    smode4 = m; a4 = a; b4 = b; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    lat = 0;
    while (!done4 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    p = prod4;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] p;
    logic [7:0] p4;
    logic [15:0] held;
    int lat;
    logic b1, dn;

    repeat (3) @(negedge clk);
    chk(busy8 == 1'b0 && done8 == 1'b0 && prod8 == 16'h0, "R1 reset state", {busy8, done8, prod8}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy8 == 1'b0 && done8 == 1'b0 && prod8 == 16'h0, "R1 after release", {busy8, done8, prod8}, 0);

    for (int i = 0; i < NVEC; i++) begin
      run8(VEC[i][32], VEC[i][31:24], VEC[i][23:16], p, lat, b1, dn);
      chk(p == VEC[i][15:0], VEC[i][32] ? "R5 signed table" : "R4 unsigned table", p, VEC[i][15:0]);
      chk(lat == 8, "R3 latency", lat, 8);
      chk(b1 == 1'b1, "R2 busy after start", b1, 1);
      chk(dn == 1'b0, "R3 done single cycle", dn, 0);
    end

    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          run4(1'(m), 4'(a), 4'(b), p4, lat);
          chk(p4 == exp4(1'(m), 4'(a), 4'(b)), m ? "R5 exhaustive 4-bit" : "R4 exhaustive 4-bit",
              p4, exp4(1'(m), 4'(a), 4'(b)));
          chk(lat == 4, "R3 latency 4-bit", lat, 4);
        end

    for (int k = 0; k < 400; k++) begin
      logic m;
      logic [7:0] a, b;
      m = 1'(k & 1);
      a = 8'($urandom);
      b = 8'($urandom);
      run8(m, a, b, p, lat, b1, dn);
      chk(p == exp8(m, a, b), m ? "R5 random" : "R4 random", p, exp8(m, a, b));
    end

    // R6: second start in the middle of a run
    @(negedge clk);
    smode8 = 1'b0; a8 = 8'd13; b8 = 8'd11; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    repeat (2) @(negedge clk);
    smode8 = 1'b1; a8 = 8'd200; b8 = 8'd200; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    lat = 3;
    while (!done8 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(prod8 == 16'h008F, "R6 mid-run start ignored", prod8, 16'h008F);
    chk(lat == 8, "R6 run length unchanged", lat, 8);
    @(negedge clk);
    chk(busy8 == 1'b0, "R6 no second run", busy8, 0);

    // R7: idle with changing inputs
    held = prod8;
    for (int k = 0; k < 6; k++) begin
      smode8 = 1'(k); a8 = 8'($urandom); b8 = 8'($urandom);
      @(negedge clk);
      chk(prod8 == held && busy8 == 1'b0, "R7 product held while idle", prod8, held);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule